// File: doc/BRIEF.md
# Sync-Pulse-Clocked Display ID Serial Transmitter

This block sends display identification bytes one way on a single serial data line. It has no serial clock of its own. Each rising edge of the vertical sync input is the bit clock. The host writes a byte into a holding register. At the next frame boundary the block copies that byte into a shift register and sends it most significant bit first. A null bit follows the eight data bits, so one byte takes nine sync pulses.

The host uses two interrupt flags to keep the line busy. The transmit flag is raised when the holding register has been copied, which means the next byte can be written while the current one is still going out. The sync flag is raised on every pulse. If no new byte has arrived by the frame boundary, the previous byte is sent again and an underrun flag is set. All flags stay set until the host writes a 1 to them.

Top module: `ddc1_vsync_tx`

## Requirements
- R1: While the enable bit (bit 0 of the control register, address 0) is 0, sync pulses are ignored: the data line stays 1, no flag is set and no frame starts.
- R2: Each rising edge of the sync input, after a two-stage synchroniser, advances the line by exactly one bit position. A sync level held high advances it only once.
- R3: A byte is sent as eight data bits, most significant bit first, followed by one null bit driven as 1. Each byte therefore spans nine pulses.
- R4: The holding register (address 1) is copied into the shift register only at a frame boundary. A write during a frame does not change the byte being sent.
- R5: The transmit flag (flags bit 0, output tx_irq) is set on the pulse that copies the holding register.
- R6: While enabled, every sync pulse sets the sync flag (flags bit 1, output sync_irq).
- R7: After enable and before the first byte is written, pulses keep the line at 1, start no frame and set no transmit flag.
- R8: If no byte has been written since the last copy, the frame boundary resends the previous byte and sets the underrun flag (flags bit 2, output underrun). If a byte has been written, the flag stays clear.
- R9: Writing the flags register (address 2) clears each flag whose data bit is 1. A 0 bit has no effect, and a set event in the same cycle wins over a clear.
- R10: After reset the line is 1, all flags are 0 and the block is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsync_in | input | 1 | Asynchronous vertical sync, used as bit clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 data, 2 flags |
| wr_data | input | 8 | Register write data |
| sda_out | output | 1 | Serial data line |
| tx_irq | output | 1 | Transmit flag: holding register was copied |
| sync_irq | output | 1 | Sync flag: a pulse was seen |
| underrun | output | 1 | Underrun flag: a byte was resent |

## Verification
The bench goes after the frame boundary. A design that reloads on the wrong pulse shifts every later bit by one position. A design that lets a mid-frame write through corrupts the byte being sent. The bench sends two back-to-back bytes and then a starved frame. A missing resend shows up as a wrong bit stream, and a wrongly set or missing underrun flag is read directly. It also holds the sync input high for a long time, which catches a level-sensitive strobe that would advance many bits. Finally, it writes zero bits to the flags register, which catches clear logic that wipes every flag at once.

// File: rtl/ddc1_tx_pkg.sv
package ddc1_tx_pkg;
   localparam int REG_AW = 2;
   typedef enum logic [REG_AW-1:0] {
      REG_CTRL  = 2'd0,
      REG_DATA  = 2'd1,
      REG_FLAGS = 2'd2
   } reg_sel_e;
   localparam int FLAG_N    = 3;
   localparam int FLAG_TX   = 0;
   localparam int FLAG_SYNC = 1;
   localparam int FLAG_UNDR = 2;
endpackage

// File: rtl/ddc1_sync_edge.sv
module ddc1_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic strobe
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              last_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else if (i == 0) chain[i] <= async_in;
            else chain[i] <= chain[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   assign strobe = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/ddc1_regs.sv
module ddc1_regs
   import ddc1_tx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              load,
   input  logic              sync_evt,
   input  logic              undr_evt,
   output logic              en,
   output logic [DATA_W-1:0] hold_data,
   output logic              pending,
   output logic [FLAG_N-1:0] flags
);
   generate
      if (DATA_W < FLAG_N) begin : g_bad
         $error("DATA_W too small for flag register");
      end
   endgenerate

   logic wr_ctrl, wr_dat, wr_flg;
   logic [FLAG_N-1:0] set_v, clr_v;

   assign wr_ctrl = wr_en && (wr_addr == REG_CTRL);
   assign wr_dat  = wr_en && (wr_addr == REG_DATA);
   assign wr_flg  = wr_en && (wr_addr == REG_FLAGS);

   always_comb begin
      set_v            = '0;
      set_v[FLAG_TX]   = load;
      set_v[FLAG_SYNC] = sync_evt;
      set_v[FLAG_UNDR] = undr_evt;
      clr_v            = wr_flg ? wr_data[FLAG_N-1:0] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en        <= 1'b0;
         hold_data <= '0;
         pending   <= 1'b0;
         flags     <= '0;
      end else begin
         if (wr_ctrl) en <= wr_data[0];
         if (wr_dat) hold_data <= wr_data;
         if (wr_dat)      pending <= 1'b1;
         else if (load)   pending <= 1'b0;
         flags <= set_v | (flags & ~clr_v);
      end
   end
endmodule

// File: rtl/ddc1_shifter.sv
module ddc1_shifter #(
   parameter int DATA_W     = 8,
   parameter bit NULL_LEVEL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              strobe,
   input  logic              pending,
   input  logic [DATA_W-1:0] hold_data,
   output logic              sda,
   output logic              load,
   output logic              undr_evt
);
   localparam int PW = $clog2(DATA_W + 2);
   localparam logic [PW-1:0] LAST_P = PW'(DATA_W + 1);
   localparam logic [PW-1:0] IDLE_P = '0;

   logic [PW-1:0]     phase;
   logic [DATA_W-1:0] shreg;
   logic              at_idle, at_null;

   assign at_idle  = (phase == IDLE_P);
   assign at_null  = (phase == LAST_P);
   assign load     = en && strobe && ((at_idle && pending) || at_null);
   assign undr_evt = load && !pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= IDLE_P;
         shreg <= '0;
      end else if (!en) begin
         phase <= IDLE_P;
      end else if (load) begin
         shreg <= hold_data;
         phase <= PW'(1);
      end else if (strobe && !at_idle) begin
         shreg <= shreg << 1;
         phase <= phase + PW'(1);
      end
   end

   always_comb begin
      if (at_idle)      sda = 1'b1;
      else if (at_null) sda = NULL_LEVEL;
      else              sda = shreg[DATA_W-1];
   end
endmodule

// File: rtl/ddc1_vsync_tx.sv
module ddc1_vsync_tx
   import ddc1_tx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit NULL_LEVEL  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vsync_in,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              sda_out,
   output logic              tx_irq,
   output logic              sync_irq,
   output logic              underrun
);
   logic              strobe, en, pending, load, undr_evt, sync_evt;
   logic [DATA_W-1:0] hold_data;
   logic [FLAG_N-1:0] flags;

   ddc1_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .async_in(vsync_in), .strobe(strobe)
   );

   assign sync_evt = strobe && en;

   ddc1_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .load(load), .sync_evt(sync_evt),
      .undr_evt(undr_evt), .en(en), .hold_data(hold_data),
      .pending(pending), .flags(flags)
   );

   ddc1_shifter #(.DATA_W(DATA_W), .NULL_LEVEL(NULL_LEVEL)) u_shift (
      .clk(clk), .rst_n(rst_n), .en(en), .strobe(strobe),
      .pending(pending), .hold_data(hold_data), .sda(sda_out),
      .load(load), .undr_evt(undr_evt)
   );

   assign tx_irq   = flags[FLAG_TX];
   assign sync_irq = flags[FLAG_SYNC];
   assign underrun = flags[FLAG_UNDR];
endmodule

// File: rtl/ddc1_vsync_tx_chk.sv
module ddc1_vsync_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic strobe,
   input logic load,
   input logic pending,
   input logic sda_out,
   input logic tx_irq,
   input logic sync_irq,
   input logic underrun
);
   AST_DISABLED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> sda_out); // R1
   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe); // R2
   AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe && en) |=> $stable(sda_out)); // R2
   AST_TX_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> tx_irq); // R5
   AST_SYNC_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && en) |=> sync_irq); // R6
   AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !pending) |=> underrun); // R8
endmodule

bind ddc1_vsync_tx ddc1_vsync_tx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .strobe(strobe), .load(load),
   .pending(pending), .sda_out(sda_out), .tx_irq(tx_irq),
   .sync_irq(sync_irq), .underrun(underrun)
);

// File: tb/ddc1_vsync_tx_tb.sv
`timescale 1ns/1ps
module ddc1_vsync_tx_tb;
   logic clk = 1'b0, rst_n = 1'b0, vsync_in = 1'b0, wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic sda_out, tx_irq, sync_irq, underrun;
   int checks = 0, errors = 0;
   bit exp_q[$];
   event pulse_done;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   ddc1_vsync_tx u_dut (
      .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .sda_out(sda_out),
      .tx_irq(tx_irq), .sync_irq(sync_irq), .underrun(underrun)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(input int high_len);
      @(negedge clk);
      vsync_in = 1'b1;
      repeat (high_len) @(negedge clk);
      vsync_in = 1'b0;
      repeat (4) @(negedge clk);
      -> pulse_done;
      @(negedge clk);
   endtask

   task automatic expect_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) exp_q.push_back(b[i]);
      exp_q.push_back(1'b1);
   endtask

   // monitor: R2/R3 line bit after each pulse
   initial begin
      forever begin
         @(pulse_done);
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R3 actual=%0b expected=<none>", sda_out);
         end else begin
            check("R3 line bit", sda_out, exp_q.pop_front());
         end
      end
   end

   initial begin
      #900000;
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 sda", sda_out, 1'b1);
      check("R10 tx", tx_irq, 1'b0);
      check("R10 sync", sync_irq, 1'b0);
      check("R10 undr", underrun, 1'b0);

      // R1 disabled: pulses ignored
      exp_q.push_back(1'b1); pulse(4);
      exp_q.push_back(1'b1); pulse(4);
      check("R1 sync", sync_irq, 1'b0);
      check("R1 tx", tx_irq, 1'b0);

      wr(2'd0, 8'h01);
      // R7 no byte yet
      exp_q.push_back(1'b1); pulse(4);
      check("R6 sync", sync_irq, 1'b1);
      check("R7 tx", tx_irq, 1'b0);

      // R9 zero bits do nothing, ones clear
      wr(2'd2, 8'h00);
      check("R9 keep", sync_irq, 1'b1);
      wr(2'd2, 8'h07);
      check("R9 clear", sync_irq, 1'b0);

      // R3/R4/R5 first byte
      wr(2'd1, 8'hA5);
      expect_byte(8'hA5);
      pulse(4);
      check("R5 tx", tx_irq, 1'b1);
      wr(2'd1, 8'h3C);               // R4 mid-frame write
      pulse(20);                     // R2 long high level: one bit
      for (int i = 0; i < 7; i++) pulse(4);
      expect_byte(8'h3C);
      for (int i = 0; i < 9; i++) pulse(4);
      check("R8 no undr", underrun, 1'b0);
      check("R6 sync", sync_irq, 1'b1);

      // R8 starved frame resends
      expect_byte(8'h3C);
      pulse(4);
      check("R8 undr", underrun, 1'b1);
      for (int i = 0; i < 8; i++) pulse(4);

      // R1 disable returns idle
      wr(2'd0, 8'h00);
      wr(2'd2, 8'h07);
      exp_q.push_back(1'b1); pulse(4);
      check("R1 idle sda", sda_out, 1'b1);
      check("R1 no sync", sync_irq, 1'b0);

      repeat (5) @(negedge clk);
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule